// File: doc/BRIEF.md
# Multiple-Register Load Sequencer

This block turns one multi-register load into a series of single memory reads and register-file writes. It has two modes. In word mode it reads aligned 32-bit words and fills registers from a chosen start register up to the top register (31). In string mode it reads a byte count of single bytes and packs them into as many registers as needed. The register index wraps from 31 back to 0.

The caller gives the start register, the base register field and its value, a flag that makes a base field of zero mean a literal zero, a 16-bit displacement (word mode only) and a 5-bit byte count (string mode only). The block then runs by itself. It has at most one memory read outstanding at a time, over a valid/ready request and response pair, and it presents each finished register on a write port together with its index. A write aimed at the base register is dropped unless that register is the final one of the sequence. A one-cycle done pulse ends the operation.

Top module: `mreg_load_seq`

## Requirements
- R1: After reset, and while idle, mem_req_valid_o, mem_rsp_ready_o, rf_we_o and done_o are all low.
- R2: In word mode (string_mode_i=0) the first read address is the base operand plus the sign-extended disp_i. Each later read is 4 bytes higher, and every request has mem_req_word_o=1.
- R3: In word mode, registers rt_i, rt_i+1, ... 31 are written in increasing order. Each one gets the full 32-bit response of its own read.
- R4: The base operand is zero when ra_i is 0 and ra0_lit_i is 1. In every other case it is base_val_i.
- R5: In string mode the byte count n is nb_i, and nb_i=0 means n=32. The block issues exactly n byte reads (mem_req_word_o=0) at consecutive addresses starting at the base operand, and disp_i is ignored.
- R6: In string mode, ceil(n/4) registers are written, starting at rt_i. Register 0 follows register 31, so the final index is (rt_i + ceil(n/4) - 1) mod 32.
- R7: In string mode each register holds four consecutive bytes. The lowest-addressed byte goes in bits 31:24 and the next bytes go in bits 23:16, 15:8 and 7:0. Only bits 7:0 of a byte response are used. Byte positions of the last register that receive no byte read as zero.
- R8: A write whose index equals ra_i is suppressed (rf_we_o stays low in its slot), unless that index is the final register of the sequence (31 in word mode).
- R9: A request holds its valid, address and size until accepted. No new request is raised while a response is awaited. mem_rsp_ready_o is high only while a response is awaited.
- R10: done_o is high for exactly one cycle, in the cycle right after the final register write.
- R11: A start_i pulse that arrives while an operation is running has no effect. The running operation's writes and reads are unchanged, and no second operation follows it.
- R12: A register is written in the cycle right after the response that completes it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| string_mode_i | input | 1 | 0 = word mode, 1 = string mode |
| rt_i | input | 5 | First destination register |
| ra_i | input | 5 | Base register field |
| nb_i | input | 5 | String byte count (0 means 32) |
| ra0_lit_i | input | 1 | When set, a base field of 0 selects a literal zero |
| base_val_i | input | 32 | Current value of the base register |
| disp_i | input | 16 | Signed displacement (word mode) |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_req_word_o | output | 1 | 1 = 32-bit read, 0 = byte read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Ready to take read data |
| mem_rsp_data_i | input | 32 | Read data (byte reads use bits 7:0) |
| rf_we_o | output | 1 | Register write enable |
| rf_idx_o | output | 5 | Register write index |
| rf_data_o | output | 32 | Register write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first request is raised in the cycle after start_i is taken. A register write follows one cycle after the response that completes it is accepted, and done_o follows one cycle after the final write. The bench keeps a cycle counter and stamps each accepted response, each observed write and each done pulse with it, always sampling on the falling edge. Every write's stamp must equal the stamp of the response expected to complete it, and the done stamp must be exactly one greater than the stamp of the last write. The memory model stretches both the request-accept delay and the response latency, so these timing relations are tested under back-pressure as well as with zero wait.

// File: rtl/mls_pkg.sv
package mls_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_RSP  = 3'd2,
      ST_WR   = 3'd3,
      ST_DONE = 3'd4
   } mls_state_e;

endpackage

// File: rtl/mls_ea_calc.sv
module mls_ea_calc #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int IDX_W  = 5
) (
   input  logic              string_i,
   input  logic [IDX_W-1:0]  ra_i,
   input  logic              ra0_lit_i,
   input  logic [ADDR_W-1:0] base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] ea_o
);

   logic [ADDR_W-1:0] base_op;
   logic [ADDR_W-1:0] disp_ext;

   // Sign-extend or truncate the displacement depending on widths
   generate
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_trunc
         assign disp_ext = disp_i[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      base_op = ((ra_i == '0) && ra0_lit_i) ? '0 : base_val_i;
      ea_o    = string_i ? base_op : (base_op + disp_ext);
   end

endmodule

// File: rtl/mls_packer.sv
module mls_packer #(
   parameter int  BYTES  = 4,
   localparam int DATA_W = 8 * BYTES,
   localparam int LANE_W = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              word_load_i,
   input  logic              byte_load_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] acc_o
);

   // One byte register per lane; lane 0 (first byte) lands in the top byte
   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (clear_i) begin
               q <= '0;
            end else if (word_load_i) begin
               q <= data_i[8*g +: 8];
            end else if (byte_load_i && (lane_i == LANE_W'(BYTES-1-g))) begin
               q <= data_i[7:0];
            end
         end
         assign acc_o[8*g +: 8] = q;
      end
   endgenerate

endmodule

// File: rtl/mls_idx_track.sv
module mls_idx_track #(
   parameter int  REG_CNT = 32,
   parameter int  NB_W    = 5,
   parameter int  BYTES   = 4,
   localparam int IDX_W   = $clog2(REG_CNT),
   localparam int CNT_W   = NB_W + 1,
   localparam int LANE_W  = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             string_i,
   input  logic [IDX_W-1:0] rt_i,
   input  logic [IDX_W-1:0] ra_i,
   input  logic [NB_W-1:0]  nb_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] nbytes_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [IDX_W-1:0] fin_o,
   output logic [IDX_W-1:0] ra_o,
   output logic             last_o,
   output logic             we_ok_o
);

   logic [CNT_W-1:0] regs_needed;
   logic [IDX_W-1:0] fin_nxt;
   logic [IDX_W-1:0] idx_q, fin_q, ra_q;

   always_comb begin
      nbytes_o    = (nb_i == '0) ? CNT_W'(1 << NB_W) : {1'b0, nb_i};
      regs_needed = (nbytes_o + CNT_W'(BYTES-1)) >> LANE_W;
      // Index arithmetic is modulo REG_CNT (power of two)
      fin_nxt     = string_i ? (rt_i + IDX_W'(regs_needed) - IDX_W'(1))
                             : IDX_W'(REG_CNT-1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         fin_q <= '0;
         ra_q  <= '0;
      end else if (init_i) begin
         idx_q <= rt_i;
         fin_q <= fin_nxt;
         ra_q  <= ra_i;
      end else if (adv_i) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign idx_o   = idx_q;
   assign fin_o   = fin_q;
   assign ra_o    = ra_q;
   assign last_o  = (idx_q == fin_q);
   assign we_ok_o = (idx_q != ra_q) || (idx_q == fin_q);

endmodule

// File: rtl/mreg_load_seq.sv
module mreg_load_seq
   import mls_pkg::*;
#(
   parameter int  ADDR_W  = 32,
   parameter int  DISP_W  = 16,
   parameter int  REG_CNT = 32,
   parameter int  NB_W    = 5,
   parameter int  BYTES   = 4,
   localparam int IDX_W   = $clog2(REG_CNT),
   localparam int DATA_W  = 8 * BYTES,
   localparam int CNT_W   = NB_W + 1,
   localparam int LANE_W  = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              string_mode_i,
   input  logic [IDX_W-1:0]  rt_i,
   input  logic [IDX_W-1:0]  ra_i,
   input  logic [NB_W-1:0]   nb_i,
   input  logic              ra0_lit_i,
   input  logic [ADDR_W-1:0] base_val_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   output logic              mem_req_word_o,
   input  logic              mem_rsp_valid_i,
   output logic              mem_rsp_ready_o,
   input  logic [DATA_W-1:0] mem_rsp_data_i,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_idx_o,
   output logic [DATA_W-1:0] rf_data_o,
   output logic              done_o
);

   // Elaboration-time parameter checks
   generate
      if (REG_CNT < 2 || (REG_CNT & (REG_CNT-1)) != 0) begin : g_bad_regcnt
         $error("REG_CNT must be a power of two of at least 2");
      end
      if (BYTES < 2 || (BYTES & (BYTES-1)) != 0) begin : g_bad_bytes
         $error("BYTES must be a power of two of at least 2");
      end
      if (BYTES > (1 << NB_W)) begin : g_bad_nbw
         $error("NB_W too narrow for BYTES");
      end
      if (((1 << NB_W) + BYTES - 1) / BYTES > REG_CNT) begin : g_bad_span
         $error("string length would exceed the register file");
      end
   endgenerate

   mls_state_e        state_q;
   logic              str_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [LANE_W-1:0] lane_q;

   logic [ADDR_W-1:0] ea;
   logic [CNT_W-1:0]  nbytes;
   logic [IDX_W-1:0]  cur_idx;
   logic [IDX_W-1:0]  fin_lat;
   logic [IDX_W-1:0]  ra_lat;
   logic              is_last;
   logic              we_ok;
   logic [DATA_W-1:0] acc;

   logic accept_start;
   logic rsp_fire;
   logic reg_full;

   assign accept_start = (state_q == ST_IDLE) && start_i;
   assign rsp_fire     = (state_q == ST_RSP) && mem_rsp_valid_i;
   assign reg_full     = (lane_q == LANE_W'(BYTES-1)) || (left_q == CNT_W'(1));

   mls_ea_calc #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .IDX_W  (IDX_W)
   ) u_ea (
      .string_i   (string_mode_i),
      .ra_i       (ra_i),
      .ra0_lit_i  (ra0_lit_i),
      .base_val_i (base_val_i),
      .disp_i     (disp_i),
      .ea_o       (ea)
   );

   mls_idx_track #(
      .REG_CNT (REG_CNT),
      .NB_W    (NB_W),
      .BYTES   (BYTES)
   ) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (accept_start),
      .string_i (string_mode_i),
      .rt_i     (rt_i),
      .ra_i     (ra_i),
      .nb_i     (nb_i),
      .adv_i    ((state_q == ST_WR) && !is_last),
      .nbytes_o (nbytes),
      .idx_o    (cur_idx),
      .fin_o    (fin_lat),
      .ra_o     (ra_lat),
      .last_o   (is_last),
      .we_ok_o  (we_ok)
   );

   mls_packer #(
      .BYTES (BYTES)
   ) u_pack (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (accept_start || (state_q == ST_WR)),
      .word_load_i (rsp_fire && !str_q),
      .byte_load_i (rsp_fire && str_q),
      .lane_i      (lane_q),
      .data_i      (mem_rsp_data_i),
      .acc_o       (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         str_q   <= 1'b0;
         addr_q  <= '0;
         left_q  <= '0;
         lane_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  str_q   <= string_mode_i;
                  addr_q  <= ea;
                  left_q  <= nbytes;
                  lane_q  <= '0;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready_i) begin
                  state_q <= ST_RSP;
               end
            end
            ST_RSP: begin
               if (mem_rsp_valid_i) begin
                  if (str_q) begin
                     addr_q  <= addr_q + ADDR_W'(1);
                     left_q  <= left_q - CNT_W'(1);
                     lane_q  <= lane_q + LANE_W'(1);
                     state_q <= reg_full ? ST_WR : ST_REQ;
                  end else begin
                     addr_q  <= addr_q + ADDR_W'(BYTES);
                     state_q <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               lane_q  <= '0;
               state_q <= is_last ? ST_DONE : ST_REQ;
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign mem_req_valid_o = (state_q == ST_REQ);
   assign mem_req_addr_o  = addr_q;
   assign mem_req_word_o  = !str_q;
   assign mem_rsp_ready_o = (state_q == ST_RSP);
   assign rf_we_o         = (state_q == ST_WR) && we_ok;
   assign rf_idx_o        = cur_idx;
   assign rf_data_o       = acc;
   assign done_o          = (state_q == ST_DONE);

endmodule

// File: rtl/mreg_load_seq_chk.sv
module mreg_load_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_word,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rf_we,
   input logic [IDX_W-1:0]  rf_idx,
   input logic [IDX_W-1:0]  ra_lat,
   input logic [IDX_W-1:0]  fin_lat,
   input logic              done
);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_word)));

   assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && rsp_ready));

   assert_done_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rf_we));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_write_after_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(rsp_valid && rsp_ready));

   assert_base_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && (rf_idx == ra_lat)) |-> (rf_idx == fin_lat));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !req_valid && !rsp_ready && !rf_we);

endmodule

bind mreg_load_seq mreg_load_seq_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (mem_req_valid_o),
   .req_ready (mem_req_ready_i),
   .req_addr  (mem_req_addr_o),
   .req_word  (mem_req_word_o),
   .rsp_valid (mem_rsp_valid_i),
   .rsp_ready (mem_rsp_ready_o),
   .rf_we     (rf_we_o),
   .rf_idx    (rf_idx_o),
   .ra_lat    (ra_lat),
   .fin_lat   (fin_lat),
   .done      (done_o)
);

// File: tb/tb_mreg_load_seq.sv
`timescale 1ns/1ps
module tb_mreg_load_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        string_mode_i = 1'b0;
   logic [4:0]  rt_i = '0, ra_i = '0, nb_i = '0;
   logic        ra0_lit_i = 1'b0;
   logic [31:0] base_val_i = '0;
   logic [15:0] disp_i = '0;
   logic        mem_req_valid_o, mem_req_word_o, mem_rsp_ready_o;
   logic        mem_req_ready_i = 1'b0;
   logic [31:0] mem_req_addr_o;
   logic        mem_rsp_valid_i = 1'b0;
   logic [31:0] mem_rsp_data_i = '0;
   logic        rf_we_o, done_o;
   logic [4:0]  rf_idx_o;
   logic [31:0] rf_data_o;

   mreg_load_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .string_mode_i(string_mode_i),
      .rt_i(rt_i), .ra_i(ra_i), .nb_i(nb_i), .ra0_lit_i(ra0_lit_i),
      .base_val_i(base_val_i), .disp_i(disp_i),
      .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
      .mem_req_addr_o(mem_req_addr_o), .mem_req_word_o(mem_req_word_o),
      .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_ready_o(mem_rsp_ready_o),
      .mem_rsp_data_i(mem_rsp_data_i),
      .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o), .done_o(done_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // Logs (cumulative)
   int          n_req = 0, n_wr = 0, n_done = 0;
   logic [31:0] req_addr_log [1024];
   logic        req_word_log [1024];
   int          rsp_cyc_log  [1024];
   logic [4:0]  wr_idx_log   [1024];
   logic [31:0] wr_dat_log   [1024];
   int          wr_cyc_log   [1024];
   int          done_cyc_log [1024];

   int rsp_lat = 0;
   int req_hold = 0;

   function automatic logic [7:0] byte_at(input logic [31:0] a);
      logic [7:0] m;
      m = 8'(a[7:0] * 8'd7);
      return m ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] word_at(input logic [31:0] a);
      return {byte_at(a), byte_at(a + 1), byte_at(a + 2), byte_at(a + 3)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Memory model: accepts a request after req_hold cycles, answers after rsp_lat
   initial begin : responder
      int hc;
      logic [31:0] a;
      logic w;
      hc = 0;
      forever begin
         @(negedge clk);
         if (mem_req_valid_o && !mem_req_ready_i) begin
            if (hc < req_hold) begin
               hc++;
            end else begin
               hc = 0;
               a = mem_req_addr_o;
               w = mem_req_word_o;
               mem_req_ready_i = 1'b1;
            end
         end else if (mem_req_ready_i) begin
            mem_req_ready_i = 1'b0;
            req_addr_log[n_req] = a;
            req_word_log[n_req] = w;
            repeat (rsp_lat) @(negedge clk);
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = w ? word_at(a) : {24'hFFFFFF, byte_at(a)};
            @(negedge clk);
            rsp_cyc_log[n_req] = cyc;
            n_req = n_req + 1;
            mem_rsp_valid_i = 1'b0;
            mem_rsp_data_i  = '0;
         end
      end
   end

   // Output monitor
   always @(negedge clk) begin
      if (rf_we_o) begin
         wr_idx_log[n_wr] = rf_idx_o;
         wr_dat_log[n_wr] = rf_data_o;
         wr_cyc_log[n_wr] = cyc;
         n_wr = n_wr + 1;
      end
      if (done_o) begin
         done_cyc_log[n_done] = cyc;
         n_done = n_done + 1;
      end
   end

   // One operation: compute expectation, run it, compare
   task automatic run_case(input string tag, input bit smode, input logic [4:0] rt,
                           input logic [4:0] ra, input logic [4:0] nb, input bit lit,
                           input logic [31:0] bval, input logic [15:0] disp,
                           input int lat, input int hold, input bit poke);
      logic [31:0] exp_addr [64];
      logic [4:0]  exp_idx [64];
      logic [31:0] exp_dat [64];
      int          exp_rsp [64];
      int n_ereq, n_ewr, w0, r0, d0, waited, n, regs;
      logic [31:0] base_op, ea;
      logic [4:0] fin;
      bit ok;

      base_op = (ra == 5'd0 && lit) ? 32'd0 : bval;
      n_ewr = 0;
      if (!smode) begin
         ea = base_op + {{16{disp[15]}}, disp};
         n_ereq = 32 - int'(rt);
         for (int i = 0; i < n_ereq; i++) exp_addr[i] = ea + 32'(4 * i);
         for (int i = 0; i < n_ereq; i++) begin
            logic [4:0] ix;
            ix = 5'(int'(rt) + i);
            if (!(ix == ra && ix != 5'd31)) begin
               exp_idx[n_ewr] = ix;
               exp_dat[n_ewr] = exp_addr[i][31:0] == exp_addr[i] ? word_at(exp_addr[i]) : 32'd0;
               exp_rsp[n_ewr] = i;
               n_ewr++;
            end
         end
      end else begin
         n = (nb == 5'd0) ? 32 : int'(nb);
         n_ereq = n;
         for (int i = 0; i < n; i++) exp_addr[i] = base_op + 32'(i);
         regs = (n + 3) / 4;
         fin = 5'(int'(rt) + regs - 1);
         for (int k = 0; k < regs; k++) begin
            logic [4:0] ix;
            logic [31:0] d;
            int lastb;
            ix = 5'(int'(rt) + k);
            d = 32'd0;
            for (int b = 0; b < 4; b++)
               if (4 * k + b < n) d[31 - 8*b -: 8] = byte_at(exp_addr[4*k + b]);
            lastb = (4 * k + 3 < n) ? 4 * k + 3 : n - 1;
            if (!(ix == ra && ix != fin)) begin
               exp_idx[n_ewr] = ix;
               exp_dat[n_ewr] = d;
               exp_rsp[n_ewr] = lastb;
               n_ewr++;
            end
         end
      end

      rsp_lat = lat;
      req_hold = hold;
      w0 = n_wr; r0 = n_req; d0 = n_done;

      @(negedge clk);
      string_mode_i = smode; rt_i = rt; ra_i = ra; nb_i = nb;
      ra0_lit_i = lit; base_val_i = bval; disp_i = disp;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // disp_i is irrelevant in string mode (R5): scramble it while running
      if (smode) disp_i = ~disp;

      waited = 0;
      if (poke) begin
         while (n_wr == w0 && waited < 3000) begin @(negedge clk); waited++; end
         // R11: start pulse with other settings while busy
         string_mode_i = ~smode; rt_i = 5'd0; ra_i = 5'd7; nb_i = 5'd3;
         base_val_i = 32'h0BAD_0000; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (n_done == d0 && waited < 3000) begin @(negedge clk); waited++; end
      repeat (4) @(negedge clk);

      chk(n_done - d0 == 1, "R10", {tag, " done count"}, n_done - d0, 1);
      chk(n_req - r0 == n_ereq, smode ? "R5" : "R2", {tag, " request count"},
          n_req - r0, n_ereq);
      chk(n_wr - w0 == n_ewr, smode ? "R6" : "R3", {tag, " write count"},
          n_wr - w0, n_ewr);
      if (n_req - r0 == n_ereq) begin
         ok = 1'b1;
         for (int i = 0; i < n_ereq; i++)
            if (req_addr_log[r0+i] !== exp_addr[i] || req_word_log[r0+i] !== !smode) begin
               if (ok) chk(1'b0, smode ? "R5" : "R2", {tag, " request address"},
                           req_addr_log[r0+i], exp_addr[i]);
               ok = 1'b0;
            end
         if (ok) chk(1'b1, "R2", tag, 0, 0);
      end
      if (n_wr - w0 == n_ewr) begin
         for (int k = 0; k < n_ewr; k++) begin
            chk(wr_idx_log[w0+k] == exp_idx[k], smode ? "R6" : "R3",
                {tag, " write index"}, wr_idx_log[w0+k], exp_idx[k]);
            chk(wr_dat_log[w0+k] == exp_dat[k], smode ? "R7" : "R3",
                {tag, " write data"}, wr_dat_log[w0+k], exp_dat[k]);
            if (n_req - r0 == n_ereq)
               chk(wr_cyc_log[w0+k] == rsp_cyc_log[r0 + exp_rsp[k]], "R12",
                   {tag, " write cycle"}, wr_cyc_log[w0+k], rsp_cyc_log[r0 + exp_rsp[k]]);
         end
         if (n_ewr > 0 && n_done - d0 == 1)
            chk(done_cyc_log[d0] == wr_cyc_log[w0 + n_ewr - 1] + 1, "R10",
                {tag, " done cycle"}, done_cyc_log[d0], wr_cyc_log[w0 + n_ewr - 1] + 1);
      end
      chk(!mem_req_valid_o && !rf_we_o && !done_o, "R1", {tag, " quiet after"},
          {mem_req_valid_o, rf_we_o, done_o}, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!mem_req_valid_o && !mem_rsp_ready_o && !rf_we_o && !done_o, "R1",
          "in reset", {mem_req_valid_o, mem_rsp_ready_o, rf_we_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mem_req_valid_o && !mem_rsp_ready_o && !rf_we_o && !done_o, "R1",
          "idle after reset", {mem_req_valid_o, mem_rsp_ready_o, rf_we_o, done_o}, 0);
   endtask

   task automatic t_word_basic();      // R2 R3: negative displacement
      run_case("word_basic", 1'b0, 5'd27, 5'd3, 5'd0, 1'b0, 32'h0000_1000, 16'hFFF8, 0, 0, 1'b0);
   endtask

   task automatic t_word_skip_base();  // R8 R9: base inside range, back-pressure
      run_case("word_skip", 1'b0, 5'd29, 5'd30, 5'd0, 1'b0, 32'h0004_0000, 16'h0020, 2, 2, 1'b0);
   endtask

   task automatic t_word_base_final(); // R8: base is register 31
      run_case("word_final", 1'b0, 5'd30, 5'd31, 5'd0, 1'b0, 32'h0000_8000, 16'h0004, 1, 0, 1'b0);
   endtask

   task automatic t_word_zero_base();  // R4: literal zero vs register value
      run_case("word_lit0", 1'b0, 5'd28, 5'd0, 5'd0, 1'b1, 32'hDEAD_0000, 16'h0200, 0, 1, 1'b0);
      run_case("word_reg0", 1'b0, 5'd28, 5'd0, 5'd0, 1'b0, 32'h0000_3000, 16'h0010, 0, 0, 1'b0);
   endtask

   task automatic t_string_short();    // R5 R6 R7: partial last register
      run_case("str7", 1'b1, 5'd5, 5'd2, 5'd7, 1'b0, 32'h0000_2001, 16'h1234, 1, 1, 1'b0);
   endtask

   task automatic t_string_full_wrap();// R5 R6 R8: nb=0 => 32 bytes, wrap, base skipped
      run_case("str32", 1'b1, 5'd28, 5'd1, 5'd0, 1'b0, 32'h0000_5000, 16'h0000, 0, 0, 1'b0);
   endtask

   task automatic t_string_base_final();// R8: base equals final register
      run_case("str_fin", 1'b1, 5'd30, 5'd31, 5'd5, 1'b0, 32'h0000_6003, 16'h0000, 0, 2, 1'b0);
   endtask

   task automatic t_string_one();      // R4 R7: single byte, literal zero base
      run_case("str1", 1'b1, 5'd31, 5'd0, 5'd1, 1'b1, 32'h7777_7777, 16'h0000, 3, 0, 1'b0);
   endtask

   task automatic t_busy_start();      // R11: start while busy is ignored
      run_case("busy", 1'b0, 5'd26, 5'd9, 5'd0, 1'b0, 32'h0000_9000, 16'h0008, 1, 1, 1'b1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_word_basic();
      t_word_skip_base();
      t_word_base_final();
      t_word_zero_base();
      t_string_short();
      t_string_full_wrap();
      t_string_base_final();
      t_string_one();
      t_busy_start();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule